// File: doc/BRIEF.md
# Prescaled Event Timer

This block is a free-running up-counter for a microcontroller-style peripheral set. It counts one of two event sources: a strobe that marks each internal instruction cycle, or transitions on an external pin. For the pin, software chooses whether rising or falling transitions count. The pin is brought into the system clock domain through a short synchronizer and then edge-detected. The selected events pass through a power-of-two prescaler, or software can bypass it, before they reach the counter.

A single control byte sets the counter width at run time, to either 8 or 16 bits. Each rollover produces a one-cycle overflow pulse for an interrupt controller.

The counter is reached through byte-wide reads and writes. In 16-bit mode, reading the low byte captures the high byte into a buffer, so the two bytes always come from the same instant. Writing the high byte only loads that buffer. Writing the low byte then loads both halves together. Any write to the counter restarts the prescaler.

Top module: `tick_timer`

## Requirements
- R1: After reset the control byte reads 8'hFF, both counter byte outputs read zero, and no overflow pulse is present.
- R2: With control bit 6 set (8-bit mode), the low byte wraps from 8'hFF to 8'h00 with one overflow pulse, and the high byte stays unchanged.
- R3: With control bit 6 clear (16-bit mode), the count carries from 16'h00FF to 16'h0100 with no overflow pulse, and wraps from 16'hFFFF to 16'h0000 with one overflow pulse.
- R4: With control bit 5 clear, the counter counts cycle strobes and ignores the external pin.
- R5: With control bit 5 set, the counter counts pin transitions and ignores cycle strobes. With control bit 4 clear only rising transitions count; with it set only falling transitions count.
- R6: With control bit 3 set, every selected event increments the counter by one.
- R7: With control bit 3 clear and prescale code n in bits 2:0, the counter increments once per 2^(n+1) selected events, from 1:2 for code 0 up to 1:256 for code 7.
- R8: With control bit 7 (run) clear, the count holds and no overflow pulse is raised.
- R9: A low-byte read strobe copies the high count byte into the buffer shown on the high output. The buffer keeps that value until the next read strobe or high-byte write.
- R10: A high-byte write loads only the buffer. In 16-bit mode a low-byte write loads the count as {buffer, data}; in 8-bit mode it loads only the low byte.
- R11: Any counter write clears the prescaler, so a full 2^(n+1) events are needed before the next increment.
- R12: The overflow pulse is one clock cycle wide and follows only a counted rollover.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | One-cycle strobe per internal instruction cycle |
| ext_pin | input | 1 | External count input, asynchronous |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Current control byte |
| cnt_lo_we | input | 1 | Counter low byte write strobe |
| cnt_hi_we | input | 1 | Counter high byte (buffer) write strobe |
| cnt_lo_rd | input | 1 | Low byte read strobe; captures the high byte |
| cnt_wdata | input | 8 | Counter write data |
| cnt_lo_q | output | 8 | Live low count byte |
| cnt_hi_q | output | 8 | Buffered high count byte |
| ovf_pulse | output | 1 | One-cycle rollover pulse |

## Verification
The bench sweeps all eight prescale codes against counts computed arithmetically. A divider that is off by one power of two, or that misses the 1:256 end, gives a visibly wrong quotient.

It also covers the following cases:
- The 8-bit rollover, checking that a design that lets the carry reach the high byte is caught.
- The 16-bit carry at 16'h00FF, checking that a design that raises overflow there is caught.
- Rising and falling pin edges, checking that a design that counts both edges gives double counts.
- A mid-phase counter write, checking that a stale prescaler phase would produce an early increment.
- Buffer hold across a later count, checking that a design that shows the live high byte would be caught.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int BYTE_W    = 8;
  localparam int PS_CODE_W = 3;

  typedef struct packed {
    logic                 run;
    logic                 narrow;
    logic                 ext_src;
    logic                 fall_edge;
    logic                 bypass;
    logic [PS_CODE_W-1:0] div_code;
  } tmr_ctl_t;

  localparam logic [BYTE_W-1:0] CTL_RESET = '1;
endpackage

// File: rtl/tt_pin_sync.sv
module tt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_o
);
  logic [STAGES:0] chain;
  logic            prev;

  assign chain[0] = pin;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g+1] <= 1'b0;
      else     chain[g+1] <= chain[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES];
  end

  assign edge_o = fall_sel ? (prev & ~chain[STAGES]) : (~prev & chain[STAGES]);
endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              evt_i,
  input  logic              bypass,
  input  logic [CODE_W-1:0] code,
  output logic              evt_o
);
  localparam int PS_W = 1 << CODE_W;

  logic [PS_W-1:0] pre;
  logic [PS_W-1:0] mask;

  // Low (code+1) bits all ones marks the last event of a period.
  assign mask  = (PS_W'(2) << code) - PS_W'(1);
  assign evt_o = evt_i & (bypass | ((pre & mask) == mask));

  always_ff @(posedge clk) begin
    if (rst || clr) pre <= '0;
    else if (evt_i) pre <= pre + PS_W'(1);
  end

  // R11: first event after a clear never completes a divided period
  a_r11_clear_restart: assert property (@(posedge clk) disable iff (rst)
    ($past(clr) && !clr && evt_i && !bypass) |-> !evt_o);
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              narrow,
  input  logic              inc,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic              lo_rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              ovf_o
);
  logic [BYTE_W-1:0] cnt_lo, cnt_hi, hi_buf;
  logic              lo_full, wrap;

  assign lo_full = &cnt_lo;
  assign wrap    = narrow ? lo_full : (lo_full & (&cnt_hi));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
      ovf_o  <= 1'b0;
    end else begin
      ovf_o <= 1'b0;
      if (lo_we) begin
        cnt_lo <= wdata;
        if (!narrow) cnt_hi <= hi_buf;
      end else if (inc) begin
        cnt_lo <= cnt_lo + BYTE_W'(1);
        if (!narrow && lo_full) cnt_hi <= cnt_hi + BYTE_W'(1);
        ovf_o <= wrap;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        hi_buf <= '0;
    else if (hi_we) hi_buf <= wdata;
    else if (lo_rd) hi_buf <= cnt_hi;
  end

  assign lo_q = cnt_lo;
  assign hi_q = hi_buf;

  // R2: an overflow pulse coincides with a zero low byte
  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (cnt_lo == '0));
  // R3: in 16-bit mode the whole count is zero at overflow
  a_r3_wide_wrap: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !$past(narrow)) |-> (cnt_hi == '0 && cnt_lo == '0));
  // R6: without a write the low byte holds or steps by one
  a_r6_step_one: assert property (@(posedge clk) disable iff (rst)
    !lo_we |=> (cnt_lo == $past(cnt_lo) || cnt_lo == $past(cnt_lo) + BYTE_W'(1)));
  // R9: buffer keeps its value without a read or high write
  a_r9_buf_hold: assert property (@(posedge clk) disable iff (rst)
    (!hi_we && !lo_rd) |=> $stable(hi_buf));
  // R12: pulse is a single cycle
  a_r12_ovf_single: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> !ovf_o);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_tick,
  input  logic              ext_pin,
  input  logic              ctl_we,
  input  logic [BYTE_W-1:0] ctl_wdata,
  output logic [BYTE_W-1:0] ctl_rdata,
  input  logic              cnt_lo_we,
  input  logic              cnt_hi_we,
  input  logic              cnt_lo_rd,
  input  logic [BYTE_W-1:0] cnt_wdata,
  output logic [BYTE_W-1:0] cnt_lo_q,
  output logic [BYTE_W-1:0] cnt_hi_q,
  output logic              ovf_pulse
);
  tmr_ctl_t ctl;
  logic     pin_evt, src_evt, ps_evt, cnt_wr;

  always_ff @(posedge clk) begin
    if (rst)         ctl <= tmr_ctl_t'(CTL_RESET);
    else if (ctl_we) ctl <= tmr_ctl_t'(ctl_wdata);
  end
  assign ctl_rdata = ctl;

  tt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(ext_pin), .fall_sel(ctl.fall_edge), .edge_o(pin_evt));

  assign src_evt = ctl.run & (ctl.ext_src ? pin_evt : cyc_tick);
  assign cnt_wr  = cnt_lo_we | cnt_hi_we;

  tt_prescaler #(.CODE_W(PS_CODE_W)) u_pre (
    .clk(clk), .rst(rst), .clr(cnt_wr), .evt_i(src_evt),
    .bypass(ctl.bypass), .code(ctl.div_code), .evt_o(ps_evt));

  tt_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst(rst), .narrow(ctl.narrow), .inc(ps_evt),
    .lo_we(cnt_lo_we), .hi_we(cnt_hi_we), .lo_rd(cnt_lo_rd), .wdata(cnt_wdata),
    .lo_q(cnt_lo_q), .hi_q(cnt_hi_q), .ovf_o(ovf_pulse));

  // R8: stopped timer neither counts nor signals overflow
  a_r8_stopped_hold: assert property (@(posedge clk) disable iff (rst)
    (!ctl.run && !cnt_lo_we) |=> ($stable(cnt_lo_q) && !ovf_pulse));
  // R5: cycle strobes have no effect while the pin is the source
  a_r5_pin_only: assert property (@(posedge clk) disable iff (rst)
    (ctl.ext_src && !pin_evt && !cnt_lo_we) |=> ($stable(cnt_lo_q) && !ovf_pulse));
endmodule

// File: tb/test_tick_timer.sv
`timescale 1ns/1ps
module test_tick_timer;
  logic       clk = 0, rst = 1;
  logic       cyc_tick = 0, ext_pin = 0;
  logic       ctl_we = 0, cnt_lo_we = 0, cnt_hi_we = 0, cnt_lo_rd = 0;
  logic [7:0] ctl_wdata = 0, cnt_wdata = 0;
  logic [7:0] ctl_rdata, cnt_lo_q, cnt_hi_q;
  logic       ovf_pulse;
  int         runs = 0, fails = 0, ovf_seen = 0, ovf_long = 0;
  logic       ovf_prev = 0;

  always #4 clk = ~clk;

  tick_timer i_tick_timer (
    .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .ext_pin(ext_pin),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .cnt_lo_we(cnt_lo_we), .cnt_hi_we(cnt_hi_we), .cnt_lo_rd(cnt_lo_rd),
    .cnt_wdata(cnt_wdata), .cnt_lo_q(cnt_lo_q), .cnt_hi_q(cnt_hi_q),
    .ovf_pulse(ovf_pulse));

  always @(negedge clk) begin
    if (ovf_pulse) ovf_seen++;
    if (ovf_pulse && ovf_prev) ovf_long++;
    ovf_prev = ovf_pulse;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask
  task automatic wr_lo(input logic [7:0] v);
    @(negedge clk); cnt_lo_we = 1; cnt_wdata = v;
    @(negedge clk); cnt_lo_we = 0;
  endtask
  task automatic wr_hi(input logic [7:0] v);
    @(negedge clk); cnt_hi_we = 1; cnt_wdata = v;
    @(negedge clk); cnt_hi_we = 0;
  endtask
  task automatic rd_lo();
    @(negedge clk); cnt_lo_rd = 1;
    @(negedge clk); cnt_lo_rd = 0;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); cyc_tick = 1; end
    @(negedge clk); cyc_tick = 0;
  endtask
  task automatic pin(input logic v);
    @(negedge clk); ext_pin = v;
    repeat (4) @(negedge clk);
  endtask
  task automatic load16(input int v);
    wr_hi(v[15:8]); wr_lo(v[7:0]);
  endtask
  task automatic read16(output int v);
    rd_lo(); v = {cnt_hi_q, cnt_lo_q};
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    runs++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int v, base;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk_eq("R1 ctl", ctl_rdata, 8'hFF);
    chk_eq("R1 lo", cnt_lo_q, 0);
    chk_eq("R1 hi", cnt_hi_q, 0);
    chk_eq("R1 ovf", ovf_pulse, 0);

    // R5 reset config: pin source, falling edges, 8-bit, bypass
    pin(1);
    chk_eq("R5 rising ignored", cnt_lo_q, 0);
    pin(0);
    chk_eq("R5 falling counted", cnt_lo_q, 1);
    ticks(5);
    chk_eq("R5 strobes ignored", cnt_lo_q, 1);

    // R5 rising edges
    wr_ctl(8'hA8); load16(0);
    for (int k = 0; k < 3; k++) begin pin(1); pin(0); end
    read16(v); chk_eq("R5 rising count", v, 3);

    // R4 internal source ignores pin
    wr_ctl(8'h88); load16(16'h0010);
    pin(1); pin(0); pin(1); pin(0);
    read16(v); chk_eq("R4 pin ignored", v, 16'h0010);
    ticks(7);
    read16(v); chk_eq("R4 strobes counted", v, 16'h0017);

    // R6 bypass: step one per strobe, near-exhaustive walk across 16'h00FF
    load16(16'h00F0);
    base = ovf_seen;
    for (int k = 1; k <= 40; k++) begin
      ticks(1);
      read16(v); chk_eq("R6 R3 step", v, 16'h00F0 + k);
    end
    chk_eq("R3 no ovf at byte carry", ovf_seen - base, 0);

    // R3 16-bit wrap
    load16(16'hFFFE); base = ovf_seen;
    ticks(2);
    read16(v); chk_eq("R3 wide wrap", v, 0);
    chk_eq("R3 ovf count", ovf_seen - base, 1);

    // R2 8-bit wrap, high byte frozen
    load16(16'h12FD);
    wr_ctl(8'hC8); base = ovf_seen;
    ticks(3);
    read16(v); chk_eq("R2 narrow wrap", v, 16'h1200);
    chk_eq("R2 ovf count", ovf_seen - base, 1);
    // R10 8-bit low write leaves high byte
    wr_hi(8'h77); wr_lo(8'h40);
    read16(v); chk_eq("R10 narrow low write", v, 16'h1240);

    // R10 16-bit: high write buffered until low write
    wr_ctl(8'h88); load16(16'h1240);
    wr_hi(8'h9A); rd_lo();
    read16(v); chk_eq("R10 hi write deferred", v, 16'h1240);
    wr_hi(8'h9A); wr_lo(8'hBC);
    read16(v); chk_eq("R10 commit", v, 16'h9ABC);

    // R9 buffer holds after later counting
    load16(16'h56FF); rd_lo();
    chk_eq("R9 latched", cnt_hi_q, 8'h56);
    ticks(1);
    chk_eq("R9 buffer held", cnt_hi_q, 8'h56);
    chk_eq("R9 live low", cnt_lo_q, 8'h00);
    rd_lo();
    chk_eq("R9 relatch", cnt_hi_q, 8'h57);

    // R7 sweep of every prescale code
    for (int code = 0; code < 8; code++) begin
      int n;
      wr_ctl(8'h80 | code); load16(0);
      n = (3 << (code + 1)) + (1 << code) + 1;
      ticks(n);
      read16(v); chk_eq($sformatf("R7 code %0d", code), v, n >> (code + 1));
    end

    // R11 counter write clears prescaler phase
    wr_ctl(8'h82); load16(0);
    ticks(5); load16(0);
    ticks(7);
    read16(v); chk_eq("R11 no early step", v, 0);
    ticks(1);
    read16(v); chk_eq("R11 step after full period", v, 1);

    // R8 stopped
    wr_ctl(8'h48); load16(16'h00FF); base = ovf_seen;
    ticks(10);
    read16(v); chk_eq("R8 hold", v, 16'h00FF);
    chk_eq("R8 no ovf", ovf_seen - base, 0);

    // R12 pulse width over the whole run
    chk_eq("R12 single-cycle pulses", ovf_long, 0);
    finish_run();
  end
endmodule